// File: doc/BRIEF.md
# Subsystem Reset and Idle Controller

This block produces the reset and clock-enable controls for a processor subsystem and for the external memory interface that sits beside it. Software drives three control bits through a register bus that lies outside this block: a subsystem enable, a retain bit and an idle-select bit for the memory-interface domain. A hardware-wide reset overrides all of these bits. When the enable bit is cleared, the processor subsystem is held in reset. The peripheral configuration group is reset with it only when the retain bit is 0. That group holds the bus priority registers, the memory-interface settings and the host-interface control.

The memory-interface domain changes state only when the core issues an IDLE strobe. Writing the idle-select bit has no effect on its own. The strobe moves the domain into idle or back out of it, according to the value of the select bit at that moment. While the domain is idle, its clock enable is low. That enable is held in a latch that is transparent while the clock is low, so the gated clock has no glitches. Two sticky flags catch software mistakes. One is set when a memory request arrives while the domain is idle. The other is set when the subsystem is enabled while the retain bit is 0.

Each reset output asserts asynchronously and releases synchronously through its own two-flop synchronizer.

Top module: `subsys_rstidle_ctrl`

## Requirements
- R1: While `hw_rst_n` is 0, both `sub_rst_n` and `cfg_rst_n` go low at once, without waiting for a clock edge, whatever value `retain_bit` holds.
- R2: While `enable_bit` is 0, `sub_rst_n` is low, and it goes low at once when `enable_bit` falls.
- R3: While `enable_bit` is 0 and `retain_bit` is 0, `cfg_rst_n` is low, and it goes low at once.
- R4: While `retain_bit` is 1, clearing `enable_bit` leaves `cfg_rst_n` high.
- R5: A 0-to-1 change of `enable_bit`, seen at a rising clock edge while `retain_bit` is 0, sets `retain_warn` at that edge. The flag stays set until a hardware reset.
- R6: A change of `idle_sel` with no `idle_strobe` leaves `idle_flag` and `mem_clk_en` unchanged.
- R7: An `idle_strobe` at a rising edge while `idle_sel` is 1 sets `idle_flag` at that edge. In the low phase that follows, `mem_clk_en` becomes 0, and `mem_gclk` then stays low through the next high phase.
- R8: An `idle_strobe` at a rising edge while `idle_sel` is 0 clears `idle_flag` at that edge. In the low phase that follows, `mem_clk_en` becomes 1, and `mem_gclk` then follows `clk` again.
- R9: `mem_req` at a rising edge while `idle_flag` is 1 sets `req_err` at that edge, and the flag stays set. A request while the domain is running does not set it.
- R10: A hardware reset clears `idle_flag`, `req_err` and `retain_warn` at the next rising edge and sets `mem_clk_en` to 1.
- R11: A reset output goes high at the second rising edge after its reset condition is removed, and not at the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subsystem clock |
| hw_rst_n | input | 1 | Global hardware reset, active low |
| enable_bit | input | 1 | Subsystem enable control bit |
| retain_bit | input | 1 | 1 keeps the configuration group out of reset when the subsystem is disabled |
| idle_sel | input | 1 | Idle-select bit for the memory-interface domain |
| idle_strobe | input | 1 | IDLE instruction strobe from the core, one cycle |
| mem_req | input | 1 | External memory request |
| sub_rst_n | output | 1 | Processor subsystem reset, active low |
| cfg_rst_n | output | 1 | Peripheral configuration group reset, active low |
| mem_clk_en | output | 1 | Latched clock enable of the memory-interface domain |
| mem_gclk | output | 1 | Gated clock of the memory-interface domain |
| idle_flag | output | 1 | 1 while the memory-interface domain is idle |
| req_err | output | 1 | Sticky flag: a memory request arrived while the domain was idle |
| retain_warn | output | 1 | Sticky flag: the subsystem was enabled while retain was 0 |

## Verification
A wrong domain state shows on `idle_flag` at the edge that follows the strobe. The same fault reaches `mem_clk_en` and `mem_gclk` within half a cycle after that, so a stuck or early commit shows up within one clock. A fault in a reset path shows up as a reset output that stays high during a disable or a hardware reset, with no clock needed. It also shows up as a release that comes one edge early or never comes. A sticky flag that does not hold, or that sets on a legal request, can be seen from the very next edge, and on every later one.

// File: rtl/sric_pkg.sv
// Shared types and constants of the subsystem reset and idle controller.
// Assumes: used by all modules of this block only.
package sric_pkg;
    // State of the memory-interface power domain
    typedef enum logic {
        DOM_RUN  = 1'b0,
        DOM_IDLE = 1'b1
    } dom_state_e;

    // Index of each reset output in the synchronizer array
    localparam int unsigned RST_SUB   = 0;
    localparam int unsigned RST_CFG   = 1;
    localparam int unsigned RST_COUNT = 2;
endpackage

// File: rtl/sric_rst_sync.sv
// Reset synchronizer: the output drops as soon as req_n goes low, and it
// rises only after STAGES rising edges with req_n high.
// Assumes: STAGES >= 2; req_n is free of glitches (it comes from registered bits).
module sric_rst_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic req_n,
    output logic rst_out_n
);
    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear the whole chain asynchronously on request
    always_ff @(posedge clk or negedge req_n) begin
        if (!req_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_out_n = chain_q[STAGES-1];

    // R11
    release_sync_chk: assert property (@(posedge clk) disable iff (!req_n)
        $rose(rst_out_n) |-> $past(req_n));
endmodule

// File: rtl/sric_idle_ctrl.sv
// Idle state machine of the memory-interface domain, plus the sticky error
// for memory requests made while idle.
// Assumes: idle_strobe is a single-cycle pulse; rst_n is synchronous, active low.
module sric_idle_ctrl
    import sric_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_sel,
    input  logic idle_strobe,
    input  logic mem_req,
    output logic idle_flag,
    output logic req_err
);
    dom_state_e state_q;

    // Commit the selected domain state only on an IDLE strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DOM_RUN;
        end else if (idle_strobe) begin
            state_q <= idle_sel ? DOM_IDLE : DOM_RUN;
        end
    end

    // Latch a request seen while idle until the next hardware reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_err <= 1'b0;
        end else if (mem_req && (state_q == DOM_IDLE)) begin
            req_err <= 1'b1;
        end
    end

    assign idle_flag = (state_q == DOM_IDLE);

    // R6
    sel_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_strobe |=> $stable(idle_flag));
    // R7
    enter_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_strobe && idle_sel) |=> idle_flag);
    // R8
    leave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_strobe && !idle_sel) |=> !idle_flag);
    // R9
    req_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && mem_req) |=> req_err);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> req_err);
endmodule

// File: rtl/sric_clk_gate.sv
// Glitch-free clock gate: the enable passes through a latch that is
// transparent while clk is low, and is ANDed with clk.
// Assumes: en_in comes from flops clocked on the rising edge of clk.
module sric_clk_gate (
    input  logic clk,
    input  logic en_in,
    output logic en_lat,
    output logic gclk
);
    // Follow the enable during the low phase, hold it while clk is high
    always_latch begin
        if (!clk) begin
            en_lat = en_in;
        end
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/subsys_rstidle_ctrl.sv
// Top of the subsystem reset and idle controller. Builds the reset
// requests from the hardware reset and the control bits, synchronizes
// their release, runs the idle domain and the clock gate, and keeps the
// sticky warning for enabling without retain.
// Assumes: control bits come from registers on clk; hw_rst_n is active low.
module subsys_rstidle_ctrl
    import sric_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic enable_bit,
    input  logic retain_bit,
    input  logic idle_sel,
    input  logic idle_strobe,
    input  logic mem_req,
    output logic sub_rst_n,
    output logic cfg_rst_n,
    output logic mem_clk_en,
    output logic mem_gclk,
    output logic idle_flag,
    output logic req_err,
    output logic retain_warn
);
    logic [RST_COUNT-1:0] rst_req_n;
    logic [RST_COUNT-1:0] rst_out_n;
    logic                 enable_q;

    // Reset requests: the subsystem follows enable, the config group also needs retain low
    always_comb begin
        rst_req_n[RST_SUB] = hw_rst_n & enable_bit;
        rst_req_n[RST_CFG] = hw_rst_n & (enable_bit | retain_bit);
    end

    // One synchronizer for each reset output
    for (genvar g = 0; g < RST_COUNT; g++) begin : g_sync
        sric_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .req_n     (rst_req_n[g]),
            .rst_out_n (rst_out_n[g])
        );
    end

    assign sub_rst_n = rst_out_n[RST_SUB];
    assign cfg_rst_n = rst_out_n[RST_CFG];

    sric_idle_ctrl u_idle (
        .clk         (clk),
        .rst_n       (hw_rst_n),
        .idle_sel    (idle_sel),
        .idle_strobe (idle_strobe),
        .mem_req     (mem_req),
        .idle_flag   (idle_flag),
        .req_err     (req_err)
    );

    sric_clk_gate u_gate (
        .clk    (clk),
        .en_in  (!idle_flag),
        .en_lat (mem_clk_en),
        .gclk   (mem_gclk)
    );

    // Track enable to detect its rising edge
    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            enable_q <= 1'b0;
        end else begin
            enable_q <= enable_bit;
        end
    end

    // Sticky warning when the subsystem is enabled without retain set
    always_ff @(posedge clk) begin
        if (!hw_rst_n) begin
            retain_warn <= 1'b0;
        end else if (enable_bit && !enable_q && !retain_bit) begin
            retain_warn <= 1'b1;
        end
    end

    // R2
    sub_held_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        !enable_bit |-> !sub_rst_n);
    // R3
    cfg_reset_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (!enable_bit && !retain_bit) |-> !cfg_rst_n);
    // R4
    cfg_retain_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (retain_bit && $past(retain_bit) && $past(cfg_rst_n)) |-> cfg_rst_n);
    // R5
    warn_sticky_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        retain_warn |=> retain_warn);
    // R7
    gate_off_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (idle_flag && $past(idle_flag)) |-> !mem_clk_en);
endmodule

// File: tb/subsys_rstidle_ctrl_bench.sv
// Directed bench for the subsystem reset and idle controller.
module subsys_rstidle_ctrl_bench;
    logic clk = 1'b0;
    logic hw_rst_n = 1'b0;
    logic enable_bit = 1'b0;
    logic retain_bit = 1'b0;
    logic idle_sel = 1'b0;
    logic idle_strobe = 1'b0;
    logic mem_req = 1'b0;
    logic sub_rst_n, cfg_rst_n, mem_clk_en, mem_gclk, idle_flag, req_err, retain_warn;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    subsys_rstidle_ctrl u_subsys_rstidle_ctrl (
        .clk         (clk),
        .hw_rst_n    (hw_rst_n),
        .enable_bit  (enable_bit),
        .retain_bit  (retain_bit),
        .idle_sel    (idle_sel),
        .idle_strobe (idle_strobe),
        .mem_req     (mem_req),
        .sub_rst_n   (sub_rst_n),
        .cfg_rst_n   (cfg_rst_n),
        .mem_clk_en  (mem_clk_en),
        .mem_gclk    (mem_gclk),
        .idle_flag   (idle_flag),
        .req_err     (req_err),
        .retain_warn (retain_warn)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b", what, act, exp);
        end
    endtask

    // Move to 1 ns after the next falling edge
    task automatic adv(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_reset_release();
        adv(3);
        chk("R1 sub_rst_n in hw reset", sub_rst_n, 1'b0);
        chk("R1 cfg_rst_n in hw reset", cfg_rst_n, 1'b0);
        chk("R10 idle_flag after reset", idle_flag, 1'b0);
        chk("R10 mem_clk_en after reset", mem_clk_en, 1'b1);
        chk("R10 req_err after reset", req_err, 1'b0);
        chk("R10 retain_warn after reset", retain_warn, 1'b0);
        retain_bit = 1'b1;
        enable_bit = 1'b1;
        hw_rst_n   = 1'b1;
        adv(1);
        chk("R11 sub_rst_n after one edge", sub_rst_n, 1'b0);
        chk("R11 cfg_rst_n after one edge", cfg_rst_n, 1'b0);
        adv(1);
        chk("R11 sub_rst_n after two edges", sub_rst_n, 1'b1);
        chk("R11 cfg_rst_n after two edges", cfg_rst_n, 1'b1);
        chk("R5 no warn when retain set", retain_warn, 1'b0);
    endtask

    task automatic t_disable_retained();
        enable_bit = 1'b0;
        #1;
        chk("R2 sub_rst_n drops without clock", sub_rst_n, 1'b0);
        chk("R4 cfg_rst_n kept with retain", cfg_rst_n, 1'b1);
        adv(3);
        chk("R4 cfg_rst_n still high", cfg_rst_n, 1'b1);
        chk("R2 sub_rst_n held while disabled", sub_rst_n, 1'b0);
        enable_bit = 1'b1;
        adv(2);
        chk("R11 sub_rst_n released", sub_rst_n, 1'b1);
    endtask

    task automatic t_disable_unretained();
        retain_bit = 1'b0;
        adv(1);
        chk("R5 no warn without enable edge", retain_warn, 1'b0);
        enable_bit = 1'b0;
        #1;
        chk("R3 cfg_rst_n drops without clock", cfg_rst_n, 1'b0);
        chk("R2 sub_rst_n drops", sub_rst_n, 1'b0);
        adv(1);
        enable_bit = 1'b1;
        adv(1);
        chk("R5 warn on enable without retain", retain_warn, 1'b1);
        retain_bit = 1'b1;
        adv(3);
        chk("R5 warn sticky", retain_warn, 1'b1);
        chk("R11 cfg_rst_n released", cfg_rst_n, 1'b1);
    endtask

    task automatic t_idle_enter();
        mem_req = 1'b1;
        adv(1);
        mem_req = 1'b0;
        chk("R9 no error while running", req_err, 1'b0);
        idle_sel = 1'b1;
        adv(2);
        chk("R6 idle_flag unchanged by select", idle_flag, 1'b0);
        chk("R6 mem_clk_en unchanged by select", mem_clk_en, 1'b1);
        idle_strobe = 1'b1;
        adv(1);
        idle_strobe = 1'b0;
        chk("R7 idle_flag set", idle_flag, 1'b1);
        chk("R7 mem_clk_en low", mem_clk_en, 1'b0);
        @(posedge clk);
        #2;
        chk("R7 gated clock held low", mem_gclk, 1'b0);
    endtask

    task automatic t_req_in_idle();
        adv(1);
        chk("R9 no error before request", req_err, 1'b0);
        mem_req = 1'b1;
        adv(1);
        mem_req = 1'b0;
        chk("R9 error set on idle request", req_err, 1'b1);
        adv(2);
        chk("R9 error sticky", req_err, 1'b1);
    endtask

    task automatic t_wake();
        idle_sel = 1'b0;
        adv(2);
        chk("R6 still idle after select cleared", idle_flag, 1'b1);
        chk("R6 mem_clk_en still low", mem_clk_en, 1'b0);
        idle_strobe = 1'b1;
        adv(1);
        idle_strobe = 1'b0;
        chk("R8 idle_flag cleared", idle_flag, 1'b0);
        chk("R8 mem_clk_en restored", mem_clk_en, 1'b1);
        @(posedge clk);
        #2;
        chk("R8 gated clock running", mem_gclk, 1'b1);
        adv(1);
        chk("R9 error survives wake", req_err, 1'b1);
    endtask

    task automatic t_hw_reset_in_idle();
        idle_sel    = 1'b1;
        idle_strobe = 1'b1;
        adv(1);
        idle_strobe = 1'b0;
        chk("R7 idle again", idle_flag, 1'b1);
        hw_rst_n = 1'b0;
        #1;
        chk("R1 sub_rst_n drops on hw reset", sub_rst_n, 1'b0);
        chk("R1 cfg_rst_n drops despite retain", cfg_rst_n, 1'b0);
        adv(1);
        chk("R10 idle cleared by hw reset", idle_flag, 1'b0);
        chk("R10 clock enable back", mem_clk_en, 1'b1);
        chk("R10 req_err cleared", req_err, 1'b0);
        chk("R10 retain_warn cleared", retain_warn, 1'b0);
        hw_rst_n = 1'b1;
        adv(2);
        chk("R11 sub_rst_n released after hw reset", sub_rst_n, 1'b1);
    endtask

    initial begin
        #4000000;
        bad++;
        total++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_release();
        t_disable_retained();
        t_disable_unretained();
        t_idle_enter();
        t_req_in_idle();
        t_wake();
        t_hw_reset_in_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule